// File: doc/BRIEF.md
# RTC time transfer sequencer

This block sits on the host side of a serial link to an external real-time clock. After reset it brings the clock chip into a known state on its own. It reads the chip's status register and clears it if the oscillator-stop flag is up. It then reads the configuration register to learn whether the chip counts hours 0 to 23 or 1 to 12 with a PM flag. From then on it accepts two kinds of request: a time write, which takes binary seconds, minutes, hour, day, month and year and sends them as one burst, and a time read, which fetches the whole time in one burst and returns binary fields.

Each access is a single chip-select window, so the seven time registers are never seen half-updated. The block also handles the BCD packing, the 12-hour encoding and the century flag. The serial engine is part of the block. It drives a clock that idles low, changes its data output on the rising clock edge and samples its input on the falling edge, most significant bit first. Chip select is active high. All timing (bit rate, select setup, select hold and the gap between transfers) is derived from a system clock frequency parameter.

The year on the write side is given as years since 1900 (0 to 199). The year on the read side is returned as a full calendar year.

Top module: `rtc_time_sequencer`

## Requirements
- R1: While reset is held, `rtc_ce`, `rtc_sck` and `get_valid` are low and `busy` is high. The first transfer after reset is the two bytes 0xFC 0x00, a single read of the status register at address 15.
- R2: If bit 4 of the second byte received in that read is 1, the next transfer is the two bytes 0xF8 0x00, a single write of zero to address 15. If bit 4 is 0, no such write is made.
- R3: Start-up ends with the two-byte transfer 0xEC 0x00, a single read of address 14. Bit 5 of the received data byte selects 24-hour mode (1) or 12-hour mode (0). `busy` then falls.
- R4: A time write is one 8-byte transfer. The bytes are 0x00, then BCD seconds, BCD minutes, the hour byte, 0x00 for the weekday, BCD day and the month byte, then the BCD year.
- R5: In 24-hour mode the hour byte is BCD(h). In 12-hour mode it is BCD((h+11) mod 12 + 1), with bit 5 set when h is 12 or more.
- R6: The year byte is BCD(year mod 100). The month byte has bit 7 set when the year since 1900 is 100 or more.
- R7: A time read is one 8-byte transfer whose first byte is 0x04 and whose other bytes are 0x00. `get_valid` is high for exactly one cycle, the first cycle in which `busy` is low, and the fields come from received bytes 1 to 7 (seconds, minutes, hour, weekday ignored, day, month, year).
- R8: On a read, the month has bit 7 masked off and the year is 2000 plus the BCD year. In 12-hour mode the hour is (BCD value with bit 5 masked) mod 12, plus 12 if bit 5 is set. In 24-hour mode it is the plain BCD value.
- R9: `rtc_sck` idles low and each half period lasts CLK_HZ/(2*SCK_HZ) cycles. `rtc_mosi` changes only when `rtc_sck` rises, most significant bit first, and the device data is taken when `rtc_sck` falls.
- R10: `rtc_ce` rises at least SETUP_US microseconds of clock cycles before the first `rtc_sck` rise. It stays high at least HOLD_US after the last fall, and stays low at least RECOV_US before it rises again.
- R11: `busy` goes high the cycle after a request is accepted and stays high until the select recovery time has elapsed. Requests made while `busy` is high are ignored. If a write and a read are requested in the same cycle, the write is taken.
- R12: Whenever `busy` is low, `rtc_ce` and `rtc_sck` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_req | input | 1 | Request a time write (taken when idle) |
| set_sec | input | 6 | Seconds to write, 0-59 |
| set_min | input | 6 | Minutes to write, 0-59 |
| set_hour | input | 5 | Hour to write, 0-23 |
| set_mday | input | 5 | Day of month to write, 1-31 |
| set_mon | input | 4 | Month to write, 1-12 |
| set_year | input | 8 | Years since 1900, 0-199 |
| get_req | input | 1 | Request a time read (taken when idle) |
| busy | output | 1 | Start-up or a transfer is in progress |
| get_valid | output | 1 | One-cycle pulse: read fields are valid |
| get_sec | output | 6 | Seconds read |
| get_min | output | 6 | Minutes read |
| get_hour | output | 5 | Hour read, 0-23 |
| get_mday | output | 5 | Day of month read |
| get_mon | output | 4 | Month read |
| get_year | output | 12 | Full calendar year read |
| rtc_ce | output | 1 | Chip select to the clock chip, active high |
| rtc_sck | output | 1 | Serial clock, idles low |
| rtc_mosi | output | 1 | Serial data to the clock chip |
| rtc_miso | input | 1 | Serial data from the clock chip |

## Verification
The bench builds the block with CLK_HZ = 8 MHz, SCK_HZ = 1 MHz and the default 31/1/62 microsecond select timing. A half bit period is then 4 cycles, the setup window 248 cycles and the recovery gap 496 cycles. At these values one 8-byte burst, with both select windows, takes about 1,300 cycles. Dozens of writes and reads fit in the run, and both start-up paths (with and without the stop flag) and both hour modes are reached through two resets. The exact half-period and the minimum setup, hold and recovery windows are measured at cycle resolution by the device model.

// File: rtl/rtcseq_pkg.sv
// Package: shared constants, state types and BCD helpers for the RTC
// time transfer sequencer.
// Assumes: command byte = {address[3:0], op[1:0], 2'b00}, most significant
// bit sent first.
package rtcseq_pkg;

    localparam int FRAME_BYTES = 8;

    // register addresses on the clock chip that the sequencer uses
    localparam logic [3:0] ADDR_TIME   = 4'd0;
    localparam logic [3:0] ADDR_CONFIG = 4'd14;
    localparam logic [3:0] ADDR_STATUS = 4'd15;

    // transfer kinds carried in the command byte
    localparam logic [1:0] OP_BURST_WR = 2'b00;
    localparam logic [1:0] OP_BURST_RD = 2'b01;
    localparam logic [1:0] OP_ONE_WR   = 2'b10;
    localparam logic [1:0] OP_ONE_RD   = 2'b11;

    // bit positions that the chip defines
    localparam int STOP_FLAG_BIT = 4;
    localparam int MODE24_BIT    = 5;
    localparam int PM_BIT        = 5;
    localparam int CENTURY_BIT   = 7;

    typedef enum logic [2:0] {
        ENG_IDLE, ENG_SETUP, ENG_HIGH, ENG_LOW, ENG_HOLD, ENG_RECOV
    } eng_state_t;

    typedef enum logic [2:0] {
        SQ_RD_STAT, SQ_CLR_STAT, SQ_RD_CFG, SQ_IDLE, SQ_SET, SQ_GET
    } seq_state_t;

    function automatic logic [7:0] cmd_byte(input logic [3:0] addr,
                                            input logic [1:0] op);
        return {addr, op, 2'b00};
    endfunction

    // binary 0-99 to packed BCD
    function automatic logic [7:0] to_bcd(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] units;
        tens  = v / 8'd10;
        units = v - tens * 8'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    // packed BCD to binary
    function automatic logic [7:0] from_bcd(input logic [7:0] b);
        return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    endfunction

endpackage

// File: rtl/rtcseq_spi_engine.sv
// Module: serial transfer engine for the RTC link.
// Shifts a frame of up to MAX_BYTES bytes, MSB first. The clock idles low,
// data changes on the rising edge and the input is taken on the falling edge.
// Select (active high) gets setup, hold and recovery windows counted in
// system clocks derived from CLK_HZ. done pulses once recovery has elapsed.
// Assumes: start is only raised while idle; nbytes is 1..MAX_BYTES.
module rtcseq_spi_engine
    import rtcseq_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SCK_HZ    = 1_000_000,
    parameter int SETUP_US  = 31,
    parameter int HOLD_US   = 1,
    parameter int RECOV_US  = 62,
    parameter int MAX_BYTES = 8,
    localparam int FRAME_W  = MAX_BYTES * 8,
    localparam int BYTE_W   = $clog2(MAX_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BYTE_W-1:0]  nbytes,
    input  logic [FRAME_W-1:0] tx_frame,
    output logic [FRAME_W-1:0] rx_frame,
    output logic               done,
    output logic               ce,
    output logic               sck,
    output logic               mosi,
    input  logic               miso
);

    localparam int CYC_US    = CLK_HZ / 1_000_000;
    localparam int HALF_CYC  = CLK_HZ / (2 * SCK_HZ);
    localparam int SETUP_CYC = SETUP_US * CYC_US;
    localparam int HOLD_CYC  = HOLD_US * CYC_US;
    localparam int RECOV_CYC = RECOV_US * CYC_US;
    localparam int MAX_A     = (SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC;
    localparam int MAX_B     = (HALF_CYC > HOLD_CYC) ? HALF_CYC : HOLD_CYC;
    localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int BIT_W     = $clog2(FRAME_W + 1);

    localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

    eng_state_t          st;
    logic [CNT_W-1:0]    cnt;
    logic [BIT_W-1:0]    bits_left;
    logic [FRAME_W-1:0]  shreg;

    assign rx_frame = shreg;

    // sequence select, clock edges and the shift register through one transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ENG_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            shreg     <= '0;
            done      <= 1'b0;
            ce        <= 1'b0;
            sck       <= 1'b0;
            mosi      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ENG_IDLE: begin
                    if (start) begin
                        ce        <= 1'b1;
                        cnt       <= SETUP_LD;
                        bits_left <= BIT_W'({nbytes, 3'b000});
                        shreg     <= tx_frame;
                        st        <= ENG_SETUP;
                    end
                end
                ENG_SETUP: begin
                    if (cnt == '0) begin
                        sck  <= 1'b1;
                        mosi <= shreg[FRAME_W-1];
                        cnt  <= HALF_LD;
                        st   <= ENG_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_HIGH: begin
                    if (cnt == '0) begin
                        sck       <= 1'b0;
                        shreg     <= {shreg[FRAME_W-2:0], miso};
                        bits_left <= bits_left - 1'b1;
                        cnt       <= HALF_LD;
                        st        <= ENG_LOW;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_LOW: begin
                    if (cnt == '0) begin
                        if (bits_left == '0) begin
                            mosi <= 1'b0;
                            cnt  <= HOLD_LD;
                            st   <= ENG_HOLD;
                        end else begin
                            sck  <= 1'b1;
                            mosi <= shreg[FRAME_W-1];
                            cnt  <= HALF_LD;
                            st   <= ENG_HIGH;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_HOLD: begin
                    if (cnt == '0) begin
                        ce  <= 1'b0;
                        cnt <= RECOV_LD;
                        st  <= ENG_RECOV;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_RECOV: begin
                    if (cnt == '0) begin
                        done <= 1'b1;
                        st   <= ENG_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // R9: data output may only move on a rising clock, never while it is high
    a_r9_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R10: the serial clock is only ever high inside a select window
    a_r10_sck_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> ce);

    // R10: a select window opens with the clock still low
    a_r10_ce_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce) |=> !sck);

endmodule

// File: rtl/rtcseq_codec.sv
// Module: combinational packing of binary time fields into the seven data
// bytes of a burst, and unpacking of a received burst into binary fields.
// Handles BCD, the 12-hour encoding with a PM bit and the century flag.
// Assumes: inputs are in range (hour 0-23, year since 1900 0-199).
module rtcseq_codec
    import rtcseq_pkg::*;
(
    input  logic        mode24,
    input  logic [5:0]  w_sec,
    input  logic [5:0]  w_min,
    input  logic [4:0]  w_hour,
    input  logic [4:0]  w_mday,
    input  logic [3:0]  w_mon,
    input  logic [7:0]  w_year,
    output logic [55:0] tx_data,
    input  logic [55:0] rx_data,
    output logic [5:0]  r_sec,
    output logic [5:0]  r_min,
    output logic [4:0]  r_hour,
    output logic [4:0]  r_mday,
    output logic [3:0]  r_mon,
    output logic [11:0] r_year
);

    logic [7:0] h12, hour_b, mon_b, yr2;
    logic       pm, cent;
    logic [7:0] rh_raw, rh_v, rh_mod, rh_out, rmon_v, ryr_v;
    logic [7:0] rx_hour_b, rx_mon_b;

    // encode the hour byte for the mode found at start-up
    always_comb begin
        pm = (w_hour >= 5'd12);
        if (w_hour == 5'd0)
            h12 = 8'd12;
        else if (w_hour > 5'd12)
            h12 = {3'd0, w_hour} - 8'd12;
        else
            h12 = {3'd0, w_hour};
        if (mode24)
            hour_b = to_bcd({3'd0, w_hour});
        else
            hour_b = to_bcd(h12) | (8'(pm) << PM_BIT);
    end

    // split the year into two digits plus the century flag on the month
    always_comb begin
        cent  = (w_year >= 8'd100);
        yr2   = cent ? (w_year - 8'd100) : w_year;
        mon_b = to_bcd({4'd0, w_mon}) | (8'(cent) << CENTURY_BIT);
    end

    assign tx_data = {to_bcd({2'd0, w_sec}), to_bcd({2'd0, w_min}), hour_b,
                      8'h00, to_bcd({3'd0, w_mday}), mon_b, to_bcd(yr2)};

    assign rx_hour_b = rx_data[39:32];
    assign rx_mon_b  = rx_data[15:8];

    // decode the hour byte back to 0-23
    always_comb begin
        rh_raw = rx_hour_b & ~(8'd1 << PM_BIT);
        rh_v   = from_bcd(rh_raw);
        rh_mod = (rh_v >= 8'd12) ? (rh_v - 8'd12) : rh_v;
        if (mode24)
            rh_out = from_bcd(rx_hour_b);
        else
            rh_out = rx_hour_b[PM_BIT] ? (rh_mod + 8'd12) : rh_mod;
    end

    // strip the century flag and rebuild the full year
    always_comb begin
        rmon_v = from_bcd(rx_mon_b & ~(8'd1 << CENTURY_BIT));
        ryr_v  = from_bcd(rx_data[7:0]);
    end

    assign r_sec  = 6'(from_bcd(rx_data[55:48]));
    assign r_min  = 6'(from_bcd(rx_data[47:40]));
    assign r_hour = 5'(rh_out);
    assign r_mday = 5'(from_bcd(rx_data[23:16]));
    assign r_mon  = 4'(rmon_v);
    assign r_year = 12'd2000 + {4'd0, ryr_v};

endmodule

// File: rtl/rtc_time_sequencer.sv
// Module: top of the RTC time transfer sequencer.
// After reset: status read, conditional status clear, configuration read
// (learns 24-hour mode). Then serves time-write and time-read requests, each
// as one atomic 8-byte burst. busy covers start-up and every transfer up to
// the end of select recovery; requests seen while busy are dropped.
// Assumes: set_* fields are sampled only in the accepting cycle.
module rtc_time_sequencer
    import rtcseq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int SCK_HZ   = 1_000_000,
    parameter int SETUP_US = 31,
    parameter int HOLD_US  = 1,
    parameter int RECOV_US = 62
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_req,
    input  logic [5:0]  set_sec,
    input  logic [5:0]  set_min,
    input  logic [4:0]  set_hour,
    input  logic [4:0]  set_mday,
    input  logic [3:0]  set_mon,
    input  logic [7:0]  set_year,
    input  logic        get_req,
    output logic        busy,
    output logic        get_valid,
    output logic [5:0]  get_sec,
    output logic [5:0]  get_min,
    output logic [4:0]  get_hour,
    output logic [4:0]  get_mday,
    output logic [3:0]  get_mon,
    output logic [11:0] get_year,
    output logic        rtc_ce,
    output logic        rtc_sck,
    output logic        rtc_mosi,
    input  logic        rtc_miso
);

    localparam int FRAME_W = FRAME_BYTES * 8;
    localparam int BYTE_W  = $clog2(FRAME_BYTES + 1);
    localparam logic [BYTE_W-1:0] LEN_SHORT = BYTE_W'(2);
    localparam logic [BYTE_W-1:0] LEN_BURST = BYTE_W'(FRAME_BYTES);

    seq_state_t          st;
    logic                launch;
    logic                mode24;
    logic [FRAME_W-1:0]  tx_frame, rx_frame;
    logic [BYTE_W-1:0]   nbytes;
    logic                eng_done;
    logic [7:0]          rx_short;

    logic [5:0]  l_sec, l_min;
    logic [4:0]  l_hour, l_mday;
    logic [3:0]  l_mon;
    logic [7:0]  l_year;
    logic [55:0] enc_data;
    logic [5:0]  d_sec, d_min;
    logic [4:0]  d_hour, d_mday;
    logic [3:0]  d_mon;
    logic [11:0] d_year;

    assign busy     = (st != SQ_IDLE);
    assign rx_short = rx_frame[7:0];

    // pick the frame and its length for the transfer this state performs
    always_comb begin
        tx_frame = '0;
        nbytes   = LEN_SHORT;
        case (st)
            SQ_RD_STAT:  tx_frame[FRAME_W-1 -: 8] = cmd_byte(ADDR_STATUS, OP_ONE_RD);
            SQ_CLR_STAT: tx_frame[FRAME_W-1 -: 8] = cmd_byte(ADDR_STATUS, OP_ONE_WR);
            SQ_RD_CFG:   tx_frame[FRAME_W-1 -: 8] = cmd_byte(ADDR_CONFIG, OP_ONE_RD);
            SQ_SET: begin
                tx_frame = {cmd_byte(ADDR_TIME, OP_BURST_WR), enc_data};
                nbytes   = LEN_BURST;
            end
            SQ_GET: begin
                tx_frame[FRAME_W-1 -: 8] = cmd_byte(ADDR_TIME, OP_BURST_RD);
                nbytes   = LEN_BURST;
            end
            default: tx_frame = '0;
        endcase
    end

    // walk start-up, accept requests and react to each finished transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_RD_STAT;
            launch    <= 1'b1;
            mode24    <= 1'b0;
            get_valid <= 1'b0;
            l_sec     <= '0;
            l_min     <= '0;
            l_hour    <= '0;
            l_mday    <= '0;
            l_mon     <= '0;
            l_year    <= '0;
            get_sec   <= '0;
            get_min   <= '0;
            get_hour  <= '0;
            get_mday  <= '0;
            get_mon   <= '0;
            get_year  <= '0;
        end else begin
            launch    <= 1'b0;
            get_valid <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (set_req) begin
                        l_sec  <= set_sec;
                        l_min  <= set_min;
                        l_hour <= set_hour;
                        l_mday <= set_mday;
                        l_mon  <= set_mon;
                        l_year <= set_year;
                        st     <= SQ_SET;
                        launch <= 1'b1;
                    end else if (get_req) begin
                        st     <= SQ_GET;
                        launch <= 1'b1;
                    end
                end
                SQ_RD_STAT: begin
                    if (eng_done) begin
                        st     <= rx_short[STOP_FLAG_BIT] ? SQ_CLR_STAT : SQ_RD_CFG;
                        launch <= 1'b1;
                    end
                end
                SQ_CLR_STAT: begin
                    if (eng_done) begin
                        st     <= SQ_RD_CFG;
                        launch <= 1'b1;
                    end
                end
                SQ_RD_CFG: begin
                    if (eng_done) begin
                        mode24 <= rx_short[MODE24_BIT];
                        st     <= SQ_IDLE;
                    end
                end
                SQ_SET: begin
                    if (eng_done) st <= SQ_IDLE;
                end
                SQ_GET: begin
                    if (eng_done) begin
                        get_sec   <= d_sec;
                        get_min   <= d_min;
                        get_hour  <= d_hour;
                        get_mday  <= d_mday;
                        get_mon   <= d_mon;
                        get_year  <= d_year;
                        get_valid <= 1'b1;
                        st        <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    rtcseq_codec codec_i (
        .mode24  (mode24),
        .w_sec   (l_sec),
        .w_min   (l_min),
        .w_hour  (l_hour),
        .w_mday  (l_mday),
        .w_mon   (l_mon),
        .w_year  (l_year),
        .tx_data (enc_data),
        .rx_data (rx_frame[55:0]),
        .r_sec   (d_sec),
        .r_min   (d_min),
        .r_hour  (d_hour),
        .r_mday  (d_mday),
        .r_mon   (d_mon),
        .r_year  (d_year)
    );

    rtcseq_spi_engine #(
        .CLK_HZ    (CLK_HZ),
        .SCK_HZ    (SCK_HZ),
        .SETUP_US  (SETUP_US),
        .HOLD_US   (HOLD_US),
        .RECOV_US  (RECOV_US),
        .MAX_BYTES (FRAME_BYTES)
    ) engine_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch),
        .nbytes   (nbytes),
        .tx_frame (tx_frame),
        .rx_frame (rx_frame),
        .done     (eng_done),
        .ce       (rtc_ce),
        .sck      (rtc_sck),
        .mosi     (rtc_mosi),
        .miso     (rtc_miso)
    );

    // R12: an idle sequencer leaves the link quiet
    a_r12_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rtc_ce && !rtc_sck));

    // R11: a request seen while idle makes the block busy on the next cycle
    a_r11_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (set_req || get_req)) |=> busy);

    // R7: read results are flagged for a single cycle
    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        get_valid |=> !get_valid);

    // R7: read results only appear as the block returns to idle
    a_r7_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        get_valid |-> !busy);

endmodule

// File: tb/rtc_time_sequencer_tb_top.sv
// Bench: a behavioural clock-chip model on the serial link, directed and
// seeded-random time writes and reads, and cycle-level timing checks.
module rtc_time_sequencer_tb_top;

    localparam int CLK_HZ    = 8_000_000;
    localparam int SCK_HZ    = 1_000_000;
    localparam int CYC_US    = CLK_HZ / 1_000_000;
    localparam int HALF      = CLK_HZ / (2 * SCK_HZ);
    localparam int SETUP_MIN = 31 * CYC_US;
    localparam int HOLD_MIN  = 1 * CYC_US;
    localparam int RECOV_MIN = 62 * CYC_US;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_req = 1'b0, get_req = 1'b0;
    logic [5:0]  set_sec = '0, set_min = '0;
    logic [4:0]  set_hour = '0, set_mday = '0;
    logic [3:0]  set_mon = '0;
    logic [7:0]  set_year = '0;
    logic        busy, get_valid;
    logic [5:0]  get_sec, get_min;
    logic [4:0]  get_hour, get_mday;
    logic [3:0]  get_mon;
    logic [11:0] get_year;
    logic        rtc_ce, rtc_sck, rtc_mosi;
    logic        rtc_miso = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit mode24_exp = 1'b0;

    always #5 clk = ~clk;

    rtc_time_sequencer #(
        .CLK_HZ (CLK_HZ),
        .SCK_HZ (SCK_HZ)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .set_req (set_req), .set_sec (set_sec), .set_min (set_min),
        .set_hour (set_hour), .set_mday (set_mday), .set_mon (set_mon),
        .set_year (set_year), .get_req (get_req),
        .busy (busy), .get_valid (get_valid),
        .get_sec (get_sec), .get_min (get_min), .get_hour (get_hour),
        .get_mday (get_mday), .get_mon (get_mon), .get_year (get_year),
        .rtc_ce (rtc_ce), .rtc_sck (rtc_sck), .rtc_mosi (rtc_mosi),
        .rtc_miso (rtc_miso)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- clock-chip model ----------------
    logic [7:0] mreg [0:15];
    logic [7:0] curb [0:7];
    logic [7:0] lastb [0:7];
    logic [15:0] xhead [0:15];
    int  xlen [0:15];
    int  nxfer = 0;
    int  cyc = 0;
    int  bitc = 0, bytec = 0;
    logic [7:0] sh = '0, cmd = '0;
    logic prev_ce = 1'b0, prev_sck = 1'b0;
    int  ce_rise = 0, last_fall = 0, last_rise = 0, ce_fall = -100000;
    bit  first_sck = 1'b0;

    // follow the link at the falling system clock, away from DUT updates
    always @(negedge clk) begin
        logic [3:0] a;
        logic [7:0] ob;
        cyc++;
        if (rtc_ce && !prev_ce) begin
            check(cyc - ce_fall >= RECOV_MIN, "R10", "select recovery",
                  64'(cyc - ce_fall), 64'(RECOV_MIN));
            ce_rise = cyc; bitc = 0; bytec = 0; first_sck = 1'b1;
        end
        if (rtc_sck && !prev_sck) begin
            if (first_sck) begin
                check(cyc - ce_rise >= SETUP_MIN, "R10", "select setup",
                      64'(cyc - ce_rise), 64'(SETUP_MIN));
                first_sck = 1'b0;
            end
            last_rise = cyc;
            a  = cmd[7:4] + 4'(bytec - 1);
            ob = (bytec >= 1 && cmd[2]) ? mreg[a] : 8'h00;
            rtc_miso <= ob[7 - bitc];
        end
        if (!rtc_sck && prev_sck) begin
            check(cyc - last_rise == HALF, "R9", "high half period",
                  64'(cyc - last_rise), 64'(HALF));
            last_fall = cyc;
            sh = {sh[6:0], rtc_mosi};
            bitc++;
            if (bitc == 8) begin
                if (bytec < 8) curb[bytec] = sh;
                if (bytec == 0) cmd = sh;
                else if (!cmd[2]) begin
                    a = cmd[7:4] + 4'(bytec - 1);
                    mreg[a] = sh;
                end
                bytec++;
                bitc = 0;
            end
        end
        if (!rtc_ce && prev_ce) begin
            check(cyc - last_fall >= HOLD_MIN, "R10", "select hold",
                  64'(cyc - last_fall), 64'(HOLD_MIN));
            ce_fall = cyc;
            for (int i = 0; i < 8; i++) lastb[i] = (i < bytec) ? curb[i] : 8'hxx;
            xhead[nxfer % 16] = {curb[0], curb[1]};
            xlen[nxfer % 16]  = bytec;
            nxfer++;
        end
        prev_ce  = rtc_ce;
        prev_sck = rtc_sck;
    end

    // ---------------- expected-value functions ----------------
    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int unbcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] hour_byte(input int h, input bit m24);
        if (m24) return bcd(h);
        return ((h >= 12) ? 8'h20 : 8'h00) | bcd((h + 11) % 12 + 1);
    endfunction

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    // reset, then start-up with the given status/config contents
    task automatic do_init(input logic [7:0] stat, input logic [7:0] cfg);
        int n0;
        mreg[15] = stat;
        mreg[14] = cfg;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!rtc_ce && !rtc_sck && !get_valid && busy, "R1", "reset outputs",
              {60'd0, rtc_ce, rtc_sck, get_valid, busy}, 64'h1);
        n0 = nxfer;
        rst_n = 1'b1;
        wait_idle();
        check(xhead[n0 % 16] == 16'hFC00 && xlen[n0 % 16] == 2, "R1",
              "status read frame", {xhead[n0 % 16], 16'(xlen[n0 % 16])}, 32'hFC000002);
        if (stat[4]) begin
            check(nxfer - n0 == 3, "R2", "transfers with stop flag", 64'(nxfer - n0), 64'd3);
            check(xhead[(n0 + 1) % 16] == 16'hF800, "R2", "status clear frame",
                  xhead[(n0 + 1) % 16], 16'hF800);
            check(mreg[15] == 8'h00, "R2", "status cleared", mreg[15], 0);
        end else begin
            check(nxfer - n0 == 2, "R2", "transfers without stop flag", 64'(nxfer - n0), 64'd2);
            check(mreg[15] == stat, "R2", "status untouched", mreg[15], stat);
        end
        check(xhead[(nxfer - 1) % 16] == 16'hEC00 && xlen[(nxfer - 1) % 16] == 2, "R3",
              "config read frame", xhead[(nxfer - 1) % 16], 16'hEC00);
        mode24_exp = cfg[5];
    endtask

    // one time write, checked byte by byte at the link
    task automatic do_set(input int s, input int mi, input int h, input int d,
                          input int mo, input int y);
        int n0;
        logic [63:0] got, exp;
        n0 = nxfer;
        set_sec = 6'(s); set_min = 6'(mi); set_hour = 5'(h);
        set_mday = 5'(d); set_mon = 4'(mo); set_year = 8'(y);
        set_req = 1'b1;
        @(negedge clk);
        set_req = 1'b0;
        set_sec = '0; set_min = '0; set_hour = '0; set_year = '0;
        check(busy, "R11", "busy after write request", busy, 1);
        wait_idle();
        check(nxfer - n0 == 1 && xlen[n0 % 16] == 8, "R4", "one 8-byte burst",
              64'(xlen[n0 % 16]), 64'd8);
        got = {lastb[0], lastb[1], lastb[2], lastb[3], lastb[4], lastb[5], lastb[6], lastb[7]};
        exp = {8'h00, bcd(s), bcd(mi), 8'h00, 8'h00, bcd(d), 8'h00, 8'h00};
        check({got[63:40], got[31:16]} == {exp[63:40], exp[31:16]}, "R4",
              "write frame fields", got, exp);
        check(lastb[3] == hour_byte(h, mode24_exp), "R5", "hour byte",
              lastb[3], hour_byte(h, mode24_exp));
        check(lastb[6] == (bcd(mo) | ((y >= 100) ? 8'h80 : 8'h00)), "R6", "month byte",
              lastb[6], bcd(mo) | ((y >= 100) ? 8'h80 : 8'h00));
        check(lastb[7] == bcd(y % 100), "R6", "year byte", lastb[7], bcd(y % 100));
    endtask

    // one time read from preset model registers
    task automatic do_get(input int s, input int mi, input int h, input int d,
                          input int mo, input int yy, input bit cflag);
        int n0;
        n0 = nxfer;
        mreg[0] = bcd(s); mreg[1] = bcd(mi); mreg[2] = hour_byte(h, mode24_exp);
        mreg[3] = 8'h05;  mreg[4] = bcd(d);
        mreg[5] = bcd(mo) | (cflag ? 8'h80 : 8'h00); mreg[6] = bcd(yy);
        get_req = 1'b1;
        @(negedge clk);
        get_req = 1'b0;
        check(busy, "R11", "busy after read request", busy, 1);
        wait_idle();
        check(get_valid, "R7", "valid with idle", get_valid, 1);
        check(xhead[n0 % 16] == 16'h0400 && xlen[n0 % 16] == 8, "R7", "read frame",
              {xhead[n0 % 16], 16'(xlen[n0 % 16])}, 32'h04000008);
        check(get_sec == 6'(s) && get_min == 6'(mi) && get_mday == 5'(d), "R7",
              "sec/min/day", {get_sec, get_min, get_mday}, {6'(s), 6'(mi), 5'(d)});
        check(get_hour == 5'(h), "R8", "hour decode", get_hour, h);
        check(get_mon == 4'(mo) && get_year == 12'(2000 + yy), "R8", "month/year",
              {get_mon, get_year}, {4'(mo), 12'(2000 + yy)});
        @(negedge clk);
        check(!get_valid, "R7", "valid one cycle", get_valid, 0);
    endtask

    int n_before;

    initial begin
        void'($urandom(32'd7177));
        for (int i = 0; i < 16; i++) mreg[i] = 8'h00;

        // 24-hour mode, stop flag set
        do_init(8'h10, 8'h20);
        do_set(0, 0, 0, 1, 1, 99);
        do_set(59, 59, 23, 31, 12, 100);
        do_set(7, 30, 12, 15, 6, 199);
        for (int i = 0; i < 10; i++)
            do_set($urandom_range(59), $urandom_range(59), $urandom_range(23),
                   $urandom_range(31, 1), $urandom_range(12, 1), $urandom_range(199));
        do_get(0, 0, 0, 1, 1, 0, 1'b1);
        do_get(59, 59, 23, 31, 12, 99, 1'b0);
        for (int i = 0; i < 8; i++)
            do_get($urandom_range(59), $urandom_range(59), $urandom_range(23),
                   $urandom_range(31, 1), $urandom_range(12, 1), $urandom_range(99),
                   1'($urandom_range(1)));

        // R11: requests made while busy are dropped
        n_before = nxfer;
        set_sec = 6'd11; set_min = 6'd22; set_hour = 5'd3;
        set_mday = 5'd4; set_mon = 4'd5; set_year = 8'd106;
        set_req = 1'b1;
        @(negedge clk);
        set_req = 1'b0;
        repeat (20) @(negedge clk);
        set_sec = 6'd44; get_req = 1'b1; set_req = 1'b1;
        @(negedge clk);
        get_req = 1'b0; set_req = 1'b0;
        wait_idle();
        check(!get_valid, "R11", "no read result from dropped request", get_valid, 0);
        repeat (RECOV_MIN + 10) @(negedge clk);
        check(nxfer - n_before == 1, "R11", "dropped requests add no transfer",
              64'(nxfer - n_before), 64'd1);
        check(lastb[1] == 8'h11, "R11", "first request's data kept", lastb[1], 8'h11);

        // R11: simultaneous write and read -> write wins
        n_before = nxfer;
        set_sec = 6'd33;
        set_req = 1'b1; get_req = 1'b1;
        @(negedge clk);
        set_req = 1'b0; get_req = 1'b0;
        wait_idle();
        check(!get_valid && xhead[n_before % 16][15:8] == 8'h00, "R11",
              "write wins over read", {get_valid, xhead[n_before % 16]}, 17'h00033);
        check(!rtc_ce && !rtc_sck, "R12", "idle link quiet", {rtc_ce, rtc_sck}, 0);

        // 12-hour mode, no stop flag
        do_init(8'h00, 8'h00);
        do_set(0, 1, 0, 2, 3, 0);
        do_set(0, 1, 11, 2, 3, 1);
        do_set(0, 1, 12, 2, 3, 150);
        do_set(0, 1, 13, 2, 3, 100);
        do_set(0, 1, 23, 2, 3, 99);
        for (int i = 0; i < 6; i++)
            do_set($urandom_range(59), $urandom_range(59), $urandom_range(23),
                   $urandom_range(31, 1), $urandom_range(12, 1), $urandom_range(199));
        do_get(1, 2, 0, 3, 4, 5, 1'b1);
        do_get(1, 2, 11, 3, 4, 5, 1'b0);
        do_get(1, 2, 12, 3, 4, 5, 1'b1);
        do_get(1, 2, 23, 3, 4, 5, 1'b0);
        for (int i = 0; i < 6; i++)
            do_get($urandom_range(59), $urandom_range(59), $urandom_range(23),
                   $urandom_range(31, 1), $urandom_range(12, 1), $urandom_range(99),
                   1'($urandom_range(1)));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // watchdog: a hung run is a failure and still reports
    initial begin
        repeat (195_000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R11 watchdog: busy actual=%0d expected=0", busy);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule